// File: doc/BRIEF.md
# AC'97 Playback Frame Serializer

This block produces the outgoing serial frame for an AC'97 audio codec. It runs in the codec's bit-clock domain (12.288 MHz nominal) and emits one bit per clock, most significant bit first, together with a frame-sync line. Each frame is 256 bit periods long: a 16-bit tag slot comes first, then twelve 20-bit slots. At the nominal clock this gives a 48 kHz frame rate, so one frame lasts about 20.83 us.

A single mono sample drives both audio slots. Upstream logic presents the sample on `sample_i`. At the clock edge that starts a frame, the block captures that value and raises `sample_req_o` for one cycle. The strobe tells the producer to present the next value; the producer then has almost a whole frame to do so. In each of the two playback slots, the captured sample fills the upper bits and four zero bits follow. The tag slot flags the frame as valid and flags only the two playback slots. Every other slot is sent as zeros.

Top module: `pcm_frame_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `frame_sync_o`, `serial_data_o` and `sample_req_o` are all 0 after that edge. The first clock edge with `rst_n` high emits bit position 0 of a new frame.
- R2: A frame spans exactly 256 clock cycles. Bit positions 0 to 255 repeat without a gap, so a new frame begins every 256 cycles.
- R3: `frame_sync_o` is high for positions 0 to 15, which is the 16-cycle tag slot, and low for positions 16 to 255.
- R4: Positions 0 to 15 carry the tag word MSB first. Bit 15 is the frame-valid flag. Bit 15−s flags slot s, for s from 1 to 12. Bits 2 to 0 are zero. With the default playback slots 3 and 4, the tag word is 16'h9800.
- R5: Slot s covers positions 16+20·(s−1) to 35+20·(s−1). The left slot is 3 by default, at positions 56 to 75. The right slot is 4 by default, at positions 76 to 95. Each playback slot sends the 16-bit sample MSB first, then 4 zero bits.
- R6: `sample_req_o` is high for exactly one cycle per frame. That cycle is the one in which position 0 is on the serial line.
- R7: The sample sent in a frame is the value on `sample_i` at the clock edge that emits position 0. Changes to `sample_i` at any other time have no effect on that frame's output.
- R8: Every slot other than the tag slot and the two playback slots is sent as all zeros.
- R9: A reset applied in the middle of a frame abandons that frame. After release, output restarts at position 0 of a fresh frame, carrying the sample present at the restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec bit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 16 | Mono PCM sample offered by the upstream producer |
| sample_req_o | output | 1 | One-cycle strobe at frame start; present the next sample |
| frame_sync_o | output | 1 | Frame sync, high during the tag slot |
| serial_data_o | output | 1 | Serial frame data, MSB first per slot |

## Verification
The bench builds the block with its default parameters: a 16-bit tag slot, twelve 20-bit slots, a 16-bit sample, and playback slots 3 and 4. With a 256-cycle frame, a few frames fit easily in the run. The scoreboard therefore predicts every single bit position, across samples that are all zeros, all ones, alternating patterns and a value with the sign bit set. Between frame starts the bench puts unrelated values on the sample input, which exercises capture at the frame start. A reset in the middle of a frame shows the restart at position 0.

// File: rtl/pcm_frame_pkg.sv
// Package: shared constants, slot classification type and frame arithmetic
// for the AC'97 playback frame serializer.
package pcm_frame_pkg;

    localparam int DEF_TAG_W     = 16;
    localparam int DEF_SLOT_W    = 20;
    localparam int DEF_NUM_SLOTS = 12;
    localparam int DEF_SAMPLE_W  = 16;

    // What the slot currently on the line carries
    typedef enum logic [1:0] {
        KIND_TAG     = 2'd0,
        KIND_LEFT    = 2'd1,
        KIND_RIGHT   = 2'd2,
        KIND_EMPTY   = 2'd3
    } slot_kind_e;

    // Total bit periods in one frame
    function automatic int frame_length(input int tag_w, input int slot_w, input int n_slots);
        return tag_w + slot_w * n_slots;
    endfunction

endpackage

// File: rtl/frame_position_counter.sv
// Module: frame_position_counter
// Tracks where the serializer is inside the frame. It keeps a flat bit
// counter that wraps once per frame. Alongside it, it keeps a slot index and
// a down-counting bit index within that slot, so no division is needed.
// Assumes TAG_W and SLOT_W both fit in BIT_W bits.
module frame_position_counter #(
    parameter int TAG_W      = 16,
    parameter int SLOT_W     = 20,
    parameter int NUM_SLOTS  = 12,
    parameter int SLOT_IDX_W = 4,
    parameter int BIT_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic                  frame_start_o,
    output logic [SLOT_IDX_W-1:0] slot_idx_o,
    output logic [BIT_W-1:0]      bit_idx_o
);

    localparam int FRAME_LEN = pcm_frame_pkg::frame_length(TAG_W, SLOT_W, NUM_SLOTS);
    localparam int CNT_W     = $clog2(FRAME_LEN);

    localparam logic [CNT_W-1:0]      LAST_POS  = CNT_W'(FRAME_LEN - 1);
    localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(NUM_SLOTS);
    localparam logic [BIT_W-1:0]      TAG_TOP   = BIT_W'(TAG_W - 1);
    localparam logic [BIT_W-1:0]      SLOT_TOP  = BIT_W'(SLOT_W - 1);

    logic [CNT_W-1:0]      pos_q;
    logic [SLOT_IDX_W-1:0] slot_q;
    logic [BIT_W-1:0]      bit_q;

    // Flat frame position: counts 0..FRAME_LEN-1 and wraps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (pos_q == LAST_POS) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Slot index and bit-within-slot, stepped in lock with the flat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= TAG_TOP;
        end else if (bit_q != '0) begin
            bit_q <= bit_q - 1'b1;
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
            bit_q  <= TAG_TOP;
        end else begin
            slot_q <= slot_q + 1'b1;
            bit_q  <= SLOT_TOP;
        end
    end

    assign frame_start_o = (pos_q == '0);
    assign slot_idx_o    = slot_q;
    assign bit_idx_o     = bit_q;

endmodule

// File: rtl/sample_hold.sv
// Module: sample_hold
// Captures the upstream sample when load_i is high and keeps it for the
// rest of the frame. Assumes load_i is a single-cycle frame-start pulse.
module sample_hold #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SAMPLE_W-1:0] held_o
);

    // Hold register: loads only at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_o <= '0;
        end else if (load_i) begin
            held_o <= sample_i;
        end
    end

endmodule

// File: rtl/slot_bit_select.sv
// Module: slot_bit_select
// Decides which kind of slot is on the line and picks the current bit.
// The tag word is a constant built from the slot numbers of the two
// playback slots. A playback slot carries the held sample in its upper bits
// with zero padding below. Every other slot is zero.
// Assumes 1 <= LEFT_SLOT, RIGHT_SLOT <= NUM_SLOTS, with the two distinct.
module slot_bit_select
    import pcm_frame_pkg::*;
#(
    parameter int TAG_W      = 16,
    parameter int SLOT_W     = 20,
    parameter int NUM_SLOTS  = 12,
    parameter int SAMPLE_W   = 16,
    parameter int LEFT_SLOT  = 3,
    parameter int RIGHT_SLOT = 4,
    parameter int SLOT_IDX_W = 4,
    parameter int BIT_W      = 5
) (
    input  logic [SLOT_IDX_W-1:0] slot_idx_i,
    input  logic [BIT_W-1:0]      bit_idx_i,
    input  logic [SAMPLE_W-1:0]   sample_i,
    output slot_kind_e            kind_o,
    output logic                  bit_o
);

    localparam int WORD_W = 2 ** BIT_W;
    localparam int PAD_W  = SLOT_W - SAMPLE_W;

    // Tag word: frame-valid flag plus one flag per playback slot
    function automatic logic [WORD_W-1:0] tag_pattern();
        logic [WORD_W-1:0] t;
        t = '0;
        t[TAG_W-1]              = 1'b1;
        t[TAG_W-1-LEFT_SLOT]    = 1'b1;
        t[TAG_W-1-RIGHT_SLOT]   = 1'b1;
        return t;
    endfunction

    localparam logic [WORD_W-1:0] TAG_WORD = tag_pattern();

    // Elaboration-time configuration check
    if (LEFT_SLOT < 1 || LEFT_SLOT > NUM_SLOTS || RIGHT_SLOT < 1 ||
        RIGHT_SLOT > NUM_SLOTS || LEFT_SLOT == RIGHT_SLOT ||
        PAD_W < 0 || TAG_W < NUM_SLOTS + 1) begin : g_bad_cfg
        $error("slot_bit_select: inconsistent slot configuration");
    end

    logic [WORD_W-1:0] audio_word;

    // Sample aligned to the top of the slot, zero padded below
    assign audio_word = WORD_W'(sample_i) << PAD_W;

    // Classify the slot currently on the line
    always_comb begin
        if (slot_idx_i == '0) begin
            kind_o = KIND_TAG;
        end else if (slot_idx_i == SLOT_IDX_W'(LEFT_SLOT)) begin
            kind_o = KIND_LEFT;
        end else if (slot_idx_i == SLOT_IDX_W'(RIGHT_SLOT)) begin
            kind_o = KIND_RIGHT;
        end else begin
            kind_o = KIND_EMPTY;
        end
    end

    // Pick the bit for the current slot kind and position
    always_comb begin
        unique case (kind_o)
            KIND_TAG:              bit_o = TAG_WORD[bit_idx_i];
            KIND_LEFT, KIND_RIGHT: bit_o = audio_word[bit_idx_i];
            default:               bit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcm_frame_serializer.sv
// Module: pcm_frame_serializer (top)
// Serializes the AC'97 playback frame: a tag slot followed by NUM_SLOTS
// data slots, MSB first, one bit per bit-clock cycle. Frame sync marks the
// tag slot. A one-cycle request marks frame start, and the mono sample is
// captured at that same edge and placed in both playback slots.
// All outputs are registered. Assumes a synchronous active-low reset
// in the bit-clock domain.
module pcm_frame_serializer
    import pcm_frame_pkg::*;
#(
    parameter int TAG_W      = DEF_TAG_W,
    parameter int SLOT_W     = DEF_SLOT_W,
    parameter int NUM_SLOTS  = DEF_NUM_SLOTS,
    parameter int SAMPLE_W   = DEF_SAMPLE_W,
    parameter int LEFT_SLOT  = 3,
    parameter int RIGHT_SLOT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                sample_req_o,
    output logic                frame_sync_o,
    output logic                serial_data_o
);

    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1);
    localparam int BIT_W      = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W);

    logic                  frame_start;
    logic [SLOT_IDX_W-1:0] slot_idx;
    logic [BIT_W-1:0]      bit_idx;
    logic [SAMPLE_W-1:0]   held_sample;
    slot_kind_e            kind;
    logic                  next_bit;

    frame_position_counter #(
        .TAG_W      (TAG_W),
        .SLOT_W     (SLOT_W),
        .NUM_SLOTS  (NUM_SLOTS),
        .SLOT_IDX_W (SLOT_IDX_W),
        .BIT_W      (BIT_W)
    ) u_position (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_o (frame_start),
        .slot_idx_o    (slot_idx),
        .bit_idx_o     (bit_idx)
    );

    sample_hold #(
        .SAMPLE_W (SAMPLE_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (frame_start),
        .sample_i (sample_i),
        .held_o   (held_sample)
    );

    slot_bit_select #(
        .TAG_W      (TAG_W),
        .SLOT_W     (SLOT_W),
        .NUM_SLOTS  (NUM_SLOTS),
        .SAMPLE_W   (SAMPLE_W),
        .LEFT_SLOT  (LEFT_SLOT),
        .RIGHT_SLOT (RIGHT_SLOT),
        .SLOT_IDX_W (SLOT_IDX_W),
        .BIT_W      (BIT_W)
    ) u_select (
        .slot_idx_i (slot_idx),
        .bit_idx_i  (bit_idx),
        .sample_i   (held_sample),
        .kind_o     (kind),
        .bit_o      (next_bit)
    );

    // Output stage: register sync, data and request on the bit clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_sync_o  <= 1'b0;
            serial_data_o <= 1'b0;
            sample_req_o  <= 1'b0;
        end else begin
            frame_sync_o  <= (kind == KIND_TAG);
            serial_data_o <= next_bit;
            sample_req_o  <= frame_start;
        end
    end

endmodule

// File: rtl/pcm_frame_checker.sv
// Module: pcm_frame_checker
// Protocol checker bound to pcm_frame_serializer. It rebuilds the frame
// position from the request strobe with a counter of its own, then checks
// the sync window, the tag bits, the padding and the empty slots against
// that position.
module pcm_frame_checker #(
    parameter int TAG_W      = 16,
    parameter int SLOT_W     = 20,
    parameter int NUM_SLOTS  = 12,
    parameter int SAMPLE_W   = 16,
    parameter int LEFT_SLOT  = 3,
    parameter int RIGHT_SLOT = 4
) (
    input logic clk,
    input logic rst_n,
    input logic sample_req_o,
    input logic frame_sync_o,
    input logic serial_data_o
);

    localparam int FRAME_LEN = TAG_W + SLOT_W * NUM_SLOTS;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int RUN_W     = $clog2(FRAME_LEN + 1);
    localparam int TAG_VAL   = (1 << (TAG_W - 1)) | (1 << (TAG_W - 1 - LEFT_SLOT)) |
                               (1 << (TAG_W - 1 - RIGHT_SLOT));
    localparam int L_START   = TAG_W + (LEFT_SLOT - 1) * SLOT_W;
    localparam int R_START   = TAG_W + (RIGHT_SLOT - 1) * SLOT_W;

    logic [CNT_W-1:0] cpos;
    logic             seen;
    logic [RUN_W-1:0] sync_run;
    int               cur;
    int               slot_of_cur;
    logic             exp_tag_bit;
    logic             in_pad;
    logic             in_empty;

    // Position counter restarted by each request strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpos <= '0;
            seen <= 1'b0;
        end else if (sample_req_o) begin
            cpos <= CNT_W'(1);
            seen <= 1'b1;
        end else if (cpos == CNT_W'(FRAME_LEN - 1)) begin
            cpos <= '0;
        end else begin
            cpos <= cpos + 1'b1;
        end
    end

    // Length of the current run of frame sync high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_run <= '0;
        end else if (frame_sync_o) begin
            sync_run <= sync_run + 1'b1;
        end else begin
            sync_run <= '0;
        end
    end

    // Classify the observed position
    always_comb begin
        cur         = sample_req_o ? 0 : int'(cpos);
        slot_of_cur = (cur < TAG_W) ? 0 : ((cur - TAG_W) / SLOT_W) + 1;
        exp_tag_bit = (cur < TAG_W) ? (((TAG_VAL >> (TAG_W - 1 - cur)) & 1) == 1) : 1'b0;
        in_pad      = (cur >= L_START + SAMPLE_W && cur < L_START + SLOT_W) ||
                      (cur >= R_START + SAMPLE_W && cur < R_START + SLOT_W);
        in_empty    = (slot_of_cur != 0) && (slot_of_cur != LEFT_SLOT) &&
                      (slot_of_cur != RIGHT_SLOT);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!frame_sync_o && !serial_data_o && !sample_req_o));

    assert_frame_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (sample_req_o == (cpos == '0)));

    assert_sync_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (frame_sync_o == (cur < TAG_W)));

    assert_sync_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_sync_o) |-> (sync_run == RUN_W'(TAG_W)));

    assert_tag_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && cur < TAG_W) |-> (serial_data_o == exp_tag_bit));

    assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && in_pad) |-> !serial_data_o);

    assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req_o |=> !sample_req_o);

    assert_req_in_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req_o |-> frame_sync_o);

    assert_empty_slots_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && in_empty) |-> !serial_data_o);

endmodule

bind pcm_frame_serializer pcm_frame_checker #(
    .TAG_W      (TAG_W),
    .SLOT_W     (SLOT_W),
    .NUM_SLOTS  (NUM_SLOTS),
    .SAMPLE_W   (SAMPLE_W),
    .LEFT_SLOT  (LEFT_SLOT),
    .RIGHT_SLOT (RIGHT_SLOT)
) u_frame_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_req_o  (sample_req_o),
    .frame_sync_o  (frame_sync_o),
    .serial_data_o (serial_data_o)
);

// File: tb/tb_pcm_frame_serializer.sv
// Scoreboard bench for pcm_frame_serializer. A driver task queues the
// expected sync, data and request value for every bit position of a frame.
// A monitor pops one item at each falling edge and compares it.
module tb_pcm_frame_serializer;

    typedef struct {
        logic sync;
        logic data;
        logic req;
        int   pos;
    } exp_item_t;

    localparam logic [15:0] TAG_EXP = 16'h9800; // R4 tag with slots 3 and 4

    logic        clk;
    logic        rst_n;
    logic [15:0] sample_in;
    logic        req;
    logic        sync;
    logic        sdata;

    int          checks;
    int          errors;
    logic        mon_en;
    exp_item_t   q[$];
    logic [15:0] samples[6];

    pcm_frame_serializer #(
        .TAG_W      (16),
        .SLOT_W     (20),
        .NUM_SLOTS  (12),
        .SAMPLE_W   (16),
        .LEFT_SLOT  (3),
        .RIGHT_SLOT (4)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_i      (sample_in),
        .sample_req_o  (req),
        .frame_sync_o  (sync),
        .serial_data_o (sdata)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check_bit(input string tag, input logic act, input logic exp, input int pos);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at position %0d: got %b expected %b", tag, pos, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: queue the expected bits of one frame carrying sample s
    task automatic push_frame(input logic [15:0] s);
        for (int p = 0; p < 256; p++) begin
            exp_item_t it;
            it.pos  = p;
            it.sync = (p < 16);
            it.req  = (p == 0);
            if (p < 16)                 it.data = TAG_EXP[15 - p];
            else if (p >= 56 && p < 72) it.data = s[15 - (p - 56)];
            else if (p >= 76 && p < 92) it.data = s[15 - (p - 76)];
            else                        it.data = 1'b0;
            q.push_back(it);
        end
    endtask

    // Monitor: compare the outputs with the scoreboard away from the rising edge
    always @(negedge clk) begin
        if (mon_en && q.size() > 0) begin
            exp_item_t e;
            string dtag;
            e = q.pop_front();
            if (e.pos < 16)                                   dtag = "R4 tag";
            else if ((e.pos >= 56 && e.pos < 72) || (e.pos >= 76 && e.pos < 92))
                                                              dtag = "R5/R7 sample";
            else if ((e.pos >= 72 && e.pos < 76) || (e.pos >= 92 && e.pos < 96))
                                                              dtag = "R5 pad";
            else                                              dtag = "R8 empty";
            check_bit("R3 sync", sync, e.sync, e.pos);
            check_bit("R2/R6 request", req, e.req, e.pos);
            check_bit(dtag, sdata, e.data, e.pos);
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        checks    = 0;
        errors    = 0;
        mon_en    = 1'b0;
        rst_n     = 1'b0;
        sample_in = 16'h0000;
        samples[0] = 16'h0000;
        samples[1] = 16'hFFFF;
        samples[2] = 16'hA5C3;
        samples[3] = 16'h8001;
        samples[4] = 16'h5A3C;
        samples[5] = 16'h1234;

        // R1: outputs stay quiet in reset while the sample input moves
        repeat (3) begin
            @(negedge clk);
            sample_in = sample_in + 16'h3333;
            check_bit("R1 reset sync", sync, 1'b0, -1);
            check_bit("R1 reset data", sdata, 1'b0, -1);
            check_bit("R1 reset request", req, 1'b0, -1);
        end

        for (int f = 0; f < 5; f++) push_frame(samples[f]);
        sample_in = samples[0];
        rst_n = 1'b1;
        @(posedge clk);
        mon_en = 1'b1;

        // R7: garbage between frame starts, true sample set late in the frame
        for (int f = 0; f < 5; f++) begin
            do @(negedge clk); while (req !== 1'b1);
            sample_in = 16'hDEAD ^ 16'(f * 16'h0F0F);
            repeat (180) @(negedge clk);
            sample_in = (f < 4) ? samples[f + 1] : 16'hBEEF;
        end
        while (q.size() > 0) @(negedge clk);

        // R9: reset in the middle of a frame, then restart cleanly
        repeat (40) @(negedge clk);
        mon_en = 1'b0;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        check_bit("R9 reset sync", sync, 1'b0, -1);
        check_bit("R9 reset data", sdata, 1'b0, -1);
        check_bit("R9 reset request", req, 1'b0, -1);
        q.delete();
        push_frame(samples[5]);
        sample_in = samples[5];
        rst_n = 1'b1;
        @(posedge clk);
        mon_en = 1'b1;
        do @(negedge clk); while (req !== 1'b1);
        sample_in = 16'hFFFF;
        while (q.size() > 0) @(negedge clk);
        mon_en = 1'b0;

        finish_run();
    end

endmodule